// File: doc/BRIEF.md
# Aligned pulse-per-second clock output

This block turns a free-running 64-bit fixed-point system time value into a square wave on an output pin. Software loads a half-period and an absolute start time through a narrow write port. Once the unit is armed, it holds the wave low until the time value reaches the start time. From then on it flips the wave once every half-period. If the half-period is half a second in the counter's scaled units and the start time falls on a whole second, the pin carries a 1 Hz square wave whose edges sit on second boundaries.

The unit keeps the due time of its next edge in a register. Each edge moves that due time forward by exactly one half-period, so jitter in the time value does not build up into drift. The unit can raise a one-cycle interrupt on every level change, for a downstream controller that counts seconds. The pin is driven only when software selects it as an output and routes it to this unit. Otherwise the pin stays low.

The expected use is as follows. Write zero to the control word. Program the half-period, the start time and the pin configuration. Then write the control word with the run bit set.

Top module: `pps_clkout`

## Requirements
- R1: After reset, pin_out, pin_oe and irq_out are all 0 and the unit is stopped.
- R2: Writes with wr_en high use these word addresses: 0 is control (bit 0 run, bit 1 align-to-target, bit 2 interrupt enable); 1 and 2 are the low and high 32 bits of the half-period; 3 and 4 are the low and high 32 bits of the start target; 5 is pin configuration (bit 0 drive-as-output, bit 1 route-to-unit). Writes to any other address have no effect. A value written takes effect from the next cycle.
- R3: A control write with run and align set clears the wave and makes the start target the first due time. While time_now is below the due time, the wave does not change.
- R4: A control write with run set and align clear makes the first due time equal to time_now in the write cycle plus the half-period.
- R5: In a cycle where the unit is running and time_now is at or above the due time (unsigned compare), the wave inverts at the next clock edge. The due time then advances by exactly the half-period.
- R6: irq_out is high for one cycle, in the same cycle a new wave level appears, if interrupt enable was set. With interrupt enable clear, irq_out never rises.
- R7: pin_oe equals the drive bit. pin_out equals the wave level only when both the drive bit and the route bit are set; otherwise pin_out is 0.
- R8: A control write with run clear forces the wave low and stops all edges and interrupts until the next write that sets run.
- R9: At most one edge occurs per clock. If time_now jumps past several due times, the unit emits one edge per cycle until the due time passes time_now again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current system time in scaled fixed-point units |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| pin_out | output | 1 | Gated clock-out level |
| pin_oe | output | 1 | Pin output enable |
| irq_out | output | 1 | One-cycle pulse per wave level change |

## Verification
The bench first holds the wave until a target placed a known number of cycles ahead. A design that compares time against the target incorrectly, or loads the wrong word as the target, would toggle early or never. It then measures the spacing of pulses over a fixed window. A design that steps the due time from the observed time, rather than from the previous due time, would lose edges or drift. The bench also makes time jump by many half-periods. This exposes a design that skips straight ahead, since that design would emit far fewer edges than one per cycle. Further runs use gated pin configurations, a cleared interrupt enable, a stop write and writes to unused addresses. A design that leaks the wave, pulses the interrupt or decodes addresses too loosely would show a pin level or an interrupt count that differs from the model.

// File: rtl/pps_clkout.sv
module pps_clkout #(
  parameter int TW = 64,
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq_out
);
  localparam int NW     = TW / DW;
  localparam int A_CTRL = 0;
  localparam int A_HALF = 1;
  localparam int A_TGT  = A_HALF + NW;
  localparam int A_PIN  = A_TGT + NW;

  logic          run_q, align_q, irqen_q, drv_q, route_q;
  logic          wave_q, irq_q;
  logic [TW-1:0] half_q, tgt_q, edge_q;

  logic ctrl_wr, pin_wr, reached;
  assign ctrl_wr = wr_en && (wr_addr == AW'(A_CTRL));
  assign pin_wr  = wr_en && (wr_addr == AW'(A_PIN));
  assign reached = run_q && (time_now >= edge_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= '0;
      tgt_q   <= '0;
      drv_q   <= 1'b0;
      route_q <= 1'b0;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (wr_en && wr_addr == AW'(A_HALF + w)) half_q[w*DW +: DW] <= wr_data;
        if (wr_en && wr_addr == AW'(A_TGT + w))  tgt_q[w*DW +: DW]  <= wr_data;
      end
      if (pin_wr) begin
        drv_q   <= wr_data[0];
        route_q <= wr_data[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      align_q <= 1'b0;
      irqen_q <= 1'b0;
      wave_q  <= 1'b0;
      irq_q   <= 1'b0;
      edge_q  <= '0;
    end else if (ctrl_wr) begin
      run_q   <= wr_data[0];
      align_q <= wr_data[1];
      irqen_q <= wr_data[2];
      wave_q  <= 1'b0;
      irq_q   <= 1'b0;
      edge_q  <= wr_data[1] ? tgt_q : time_now + half_q;
    end else if (reached) begin
      wave_q <= ~wave_q;
      edge_q <= edge_q + half_q;
      irq_q  <= irqen_q;
    end else begin
      irq_q <= 1'b0;
    end
  end

  assign pin_oe  = drv_q;
  assign pin_out = wave_q & drv_q & route_q;
  assign irq_out = irq_q;
endmodule

// File: rtl/pps_clkout_chk.sv
module pps_clkout_chk #(
  parameter int TW = 64,
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [TW-1:0] time_now,
  input logic          wave,
  input logic          run,
  input logic          irq,
  input logic [TW-1:0] edge_t,
  input logic [TW-1:0] half,
  input logic          pin_oe
);
  localparam int A_PIN = 1 + 2 * (TW / DW);
  logic ctrl_wr, pin_wr;
  assign ctrl_wr = wr_en && (wr_addr == '0);
  assign pin_wr  = wr_en && (wr_addr == AW'(A_PIN));

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (wave != $past(wave))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!irq && !wave)); // R8

  AST_NO_EARLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(ctrl_wr) && ($past(time_now) < $past(edge_t))) |-> (wave == $past(wave))); // R3

  AST_STEP_BY_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(ctrl_wr) && (wave != $past(wave))) |-> (edge_t == $past(edge_t) + $past(half))); // R5

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pin_wr) |-> $stable(pin_oe)); // R7
endmodule

bind pps_clkout pps_clkout_chk #(.TW(TW), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .time_now(time_now),
  .wave(wave_q), .run(run_q), .irq(irq_q), .edge_t(edge_q), .half(half_q), .pin_oe(pin_oe)
);

// File: tb/sim_pps_clkout.sv
module sim_pps_clkout;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tnow = 64'd1000;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pin_out, pin_oe, irq_out;
  logic [63:0] jump = '0;

  pps_clkout u0 (.clk(clk), .rst_n(rst_n), .time_now(tnow), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) tnow <= tnow + 64'(STEP) + jump;

  // behavioural reference
  longint unsigned m_half, m_tgt, m_edge;
  bit m_run, m_align, m_irqen, m_drv, m_route, m_wave, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_half = 0; m_tgt = 0; m_edge = 0;
      {m_run, m_align, m_irqen, m_drv, m_route, m_wave, m_irq} = '0;
    end else begin
      bit hit;
      hit = m_run && (tnow >= m_edge);
      if (wr_en && wr_addr == 3'd0) begin
        m_edge  = wr_data[1] ? m_tgt : tnow + m_half;
        m_run   = wr_data[0]; m_align = wr_data[1]; m_irqen = wr_data[2];
        m_wave  = 0; m_irq = 0;
      end else if (hit) begin
        m_wave = !m_wave; m_edge = m_edge + m_half; m_irq = m_irqen;
      end else m_irq = 0;
      if (wr_en) case (wr_addr)
        3'd1: m_half[31:0]  = wr_data;
        3'd2: m_half[63:32] = wr_data;
        3'd3: m_tgt[31:0]   = wr_data;
        3'd4: m_tgt[63:32]  = wr_data;
        3'd5: begin m_drv = wr_data[0]; m_route = wr_data[1]; end
        default: ;
      endcase
    end
  end

  string cur_req = "R1";
  int cmp_checks = 0, cmp_errs = 0, irq_seen = 0, cycles = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit ep;
      ep = m_wave & m_drv & m_route;
      cmp_checks++;
      if (pin_out !== ep || pin_oe !== m_drv || irq_out !== m_irq) begin
        cmp_errs++;
        $display("FAIL %s: pin_out/pin_oe/irq got %b%b%b expected %b%b%b at t=%0d",
                 cur_req, pin_out, pin_oe, irq_out, ep, m_drv, m_irq, tnow);
      end
      if (irq_out) irq_seen++;
    end
  end

  int d_checks = 0, d_errs = 0;
  task automatic check(input string req, input longint got, input longint exp);
    d_checks++;
    if (got != exp) begin
      d_errs++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) if (cycles > 20000) begin
    $display("FAIL watchdog: got %0d cycles expected below 20000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", cmp_checks + d_checks + 1, cmp_errs + d_errs + 1);
    $finish;
  end

  initial begin
    int base;
    logic [63:0] t0;
    idle(2);
    cur_req = "R1";
    check("R1 pin_out", pin_out, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 irq_out", irq_out, 0);
    rst_n = 1'b1;
    idle(2);

    // aligned start and spacing
    cur_req = "R3";
    wr(0, 0);
    wr(5, 3);
    wr(1, 40); wr(2, 0);
    @(negedge clk); t0 = tnow + 64'd220;
    wr(3, t0[31:0]); wr(4, t0[63:32]);
    base = irq_seen;
    wr(0, 32'b111);
    idle(30);
    check("R3 no edge before target", irq_seen - base, 0);
    check("R3 pin low before target", pin_out, 0);
    idle(25);
    check("R3 edge after target", (irq_seen - base) > 0, 1);
    cur_req = "R5";
    idle(3);
    base = irq_seen;
    idle(80);
    check("R5 edges in 80 cycles", irq_seen - base, 10);

    // catch-up after a jump
    cur_req = "R9";
    @(posedge clk); jump = 64'd400;
    @(posedge clk); jump = '0;
    base = irq_seen;
    idle(16);
    check("R9 catch-up one edge per cycle", (irq_seen - base) >= 11, 1);

    // unaligned start
    cur_req = "R4";
    wr(0, 0);
    check("R8 stop forces low", pin_out, 0);
    base = irq_seen;
    wr(0, 32'b101);
    idle(60);
    check("R4 unaligned edges in 60 cycles", (irq_seen - base) >= 7, 1);

    // pin gating
    cur_req = "R7";
    wr(5, 1);
    idle(20);
    check("R7 driven but not routed", pin_out, 0);
    check("R7 oe follows drive", pin_oe, 1);
    wr(5, 2);
    idle(20);
    check("R7 routed but not driven oe", pin_oe, 0);
    wr(5, 3);

    // interrupt disabled
    cur_req = "R6";
    wr(0, 0);
    base = irq_seen;
    wr(0, 32'b001);
    idle(60);
    check("R6 no irq when disabled", irq_seen - base, 0);

    // unused addresses and high words
    cur_req = "R2";
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    idle(20);
    wr(0, 0);
    wr(4, 1);
    base = irq_seen;
    wr(0, 32'b111);
    idle(40);
    check("R2 high target word holds start", irq_seen - base, 0);
    check("R2 pin low", pin_out, 0);

    // stop
    cur_req = "R8";
    wr(4, 0); wr(0, 32'b101);
    idle(20);
    wr(0, 0);
    base = irq_seen;
    idle(50);
    check("R8 no irq while stopped", irq_seen - base, 0);
    check("R8 pin low while stopped", pin_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", cmp_checks + d_checks, cmp_errs + d_errs);
    $finish;
  end
endmodule